// File: doc/BRIEF.md
# Clock-Held-High Sync Detector

This block sits on the converter side of a serial data link. It watches the serial clock input and treats a clock parked high, instead of at its normal low idle level, as an out-of-band request to realign the converter. A periodic ready-cycle tick marks each conversion boundary. The block counts the consecutive ticks at which the synchronized serial clock is high. When the count reaches the threshold, it asserts the modulator reset. It also takes over the shared ready/data pin: the pin is driven low for one system clock, then held high.

The modulator leaves reset on the next falling edge of the serial clock. Several converters that share one serial clock line therefore restart on the same edge. After release, a restart timer of a fixed number of system clocks runs. A one-cycle restart pulse then marks the first ready point that carries valid data, and the block hands the pin back to the normal frame logic.

Top module: `sclk_hold_sync`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, mod_rst_o, pin_ovr_en_o, pin_ovr_val_o and restart_o are all 0.
- R2: The request is recognized on the HOLD_TICKS-th (default 4) consecutive rdy_tick_i pulse at which the synchronized serial clock is high. mod_rst_o rises in the cycle after the clock edge that samples that tick. Earlier ticks leave every output at 0.
- R3: If the synchronized serial clock is seen low before the threshold is reached, the tick count clears. A later request then needs a full HOLD_TICKS fresh ticks.
- R4: In the first cycle of a recognized request, pin_ovr_en_o=1 and pin_ovr_val_o=0. From the next cycle on, pin_ovr_val_o=1 while the override lasts.
- R5: mod_rst_o stays at 1 for as long as the serial clock stays high, however many further ticks arrive.
- R6: mod_rst_o falls SYNC_STAGES+1 clock edges after a falling edge on sclk_i. With the default of 2 stages, it is still 1 after two edges and 0 after the third.
- R7: restart_o is a one-cycle pulse in the RESTART_DLY-th cycle in which mod_rst_o is 0, counting the first such cycle as 1. The pin override stays enabled and high up to and including that cycle, and all outputs are 0 in the following cycle.
- R8: Ticks at which the synchronized serial clock is low never assert mod_rst_o.
- R9: Ticks that arrive with the serial clock high during the restart window are not counted. Counting starts only after restart_o has fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host, asynchronous to clk_i |
| rdy_tick_i | input | 1 | One-cycle pulse at each ready-cycle boundary |
| mod_rst_o | output | 1 | Holds the modulator in reset |
| pin_ovr_en_o | output | 1 | Ready/data pin is driven by this block |
| pin_ovr_val_o | output | 1 | Level forced on the pin when the override is enabled |
| restart_o | output | 1 | One-cycle mark of the first valid ready point after release |

## Verification
The hardest state to reach from the ports is a serial clock that goes high again during the restart window. Ticks then arrive while the detector is not yet armed, and they must not shorten the next request. The stimulus releases a hold, raises the serial clock a few cycles into the restart delay, and sends three ticks before restart_o fires. After the restart, three more ticks must produce nothing and the fourth must start a new reset. An earlier run also interrupts a partial count with a low period, which checks that the count clears, before it completes the request.

// File: rtl/sclk_hold_sync_pkg.sv
package sclk_hold_sync_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PULSE   = 2'd1,
    ST_HOLD    = 2'd2,
    ST_RESTART = 2'd3
  } sync_state_e;
endpackage

// File: rtl/sclk_sampler.sv
module sclk_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic sclk_s_o,
  output logic sclk_fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              sclk_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '0;
      sclk_d_q <= 1'b0;
    end else begin
      sync_q   <= {sync_q[STAGES-2:0], sclk_i};
      sclk_d_q <= sync_q[STAGES-1];
    end
  end

  assign sclk_s_o    = sync_q[STAGES-1];
  assign sclk_fall_o = sclk_d_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/hold_counter.sv
module hold_counter #(
  parameter int HOLD_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic tick_i,
  input  logic sclk_s_i,
  output logic req_o
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign req_o = arm_i & tick_i & sclk_s_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!arm_i || !sclk_s_i) cnt_q <= '0;
    else if (tick_i)             cnt_q <= req_o ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(HOLD_TICKS)); // R2
  AST_CNT_CLEAR_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_s_i && !req_o) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/restart_timer.sv
module restart_timer #(
  parameter int DLY = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int TW = $clog2(DLY + 1);
  localparam logic [TW-1:0] LOAD_VAL = TW'(DLY - 1);

  logic [TW-1:0] tmr_q;

  assign done_o = run_i & (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    tmr_q <= '0;
    else if (load_i)                tmr_q <= LOAD_VAL;
    else if (run_i && tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
  end

  AST_TMR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q <= LOAD_VAL); // R7
endmodule

// File: rtl/sync_ctrl.sv
module sync_ctrl
  import sclk_hold_sync_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic sclk_fall_i,
  input  logic tmr_done_i,
  output logic arm_o,
  output logic tmr_load_o,
  output logic tmr_run_o,
  output logic mod_rst_o,
  output logic pin_ovr_en_o,
  output logic pin_ovr_val_o,
  output logic restart_o
);
  sync_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i) state_d = ST_PULSE;
      ST_PULSE:   state_d = sclk_fall_i ? ST_RESTART : ST_HOLD;
      ST_HOLD:    if (sclk_fall_i) state_d = ST_RESTART;
      ST_RESTART: if (tmr_done_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign arm_o         = (state_q == ST_IDLE);
  assign mod_rst_o     = (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign tmr_load_o    = mod_rst_o && sclk_fall_i;
  assign tmr_run_o     = (state_q == ST_RESTART);
  assign pin_ovr_en_o  = (state_q != ST_IDLE);
  assign pin_ovr_val_o = (state_q == ST_HOLD) || (state_q == ST_RESTART);
  assign restart_o     = tmr_run_o && tmr_done_i;

  AST_PULSE_THEN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PULSE) |=> pin_ovr_en_o && pin_ovr_val_o); // R4
endmodule

// File: rtl/sclk_hold_sync.sv
module sclk_hold_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 4,
  parameter int RESTART_DLY = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic rdy_tick_i,
  output logic mod_rst_o,
  output logic pin_ovr_en_o,
  output logic pin_ovr_val_o,
  output logic restart_o
);
  logic sclk_s, sclk_fall, req, arm, tmr_load, tmr_run, tmr_done;

  sclk_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i),
    .sclk_s_o(sclk_s), .sclk_fall_o(sclk_fall)
  );

  hold_counter #(.HOLD_TICKS(HOLD_TICKS)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm), .tick_i(rdy_tick_i),
    .sclk_s_i(sclk_s), .req_o(req)
  );

  restart_timer #(.DLY(RESTART_DLY)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .run_i(tmr_run),
    .done_o(tmr_done)
  );

  sync_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .sclk_fall_i(sclk_fall),
    .tmr_done_i(tmr_done), .arm_o(arm), .tmr_load_o(tmr_load),
    .tmr_run_o(tmr_run), .mod_rst_o(mod_rst_o), .pin_ovr_en_o(pin_ovr_en_o),
    .pin_ovr_val_o(pin_ovr_val_o), .restart_o(restart_o)
  );

  AST_ENTRY_NEEDS_HIGH_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_rst_o) |-> $past(sclk_s) && $past(rdy_tick_i)); // R2
  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_rst_o && sclk_s) |=> mod_rst_o); // R5
  AST_RELEASE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mod_rst_o) |-> $past(sclk_fall)); // R6
  AST_RESTART_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o); // R7
  AST_RESTART_OUT_OF_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> !mod_rst_o && pin_ovr_en_o && pin_ovr_val_o); // R7
  AST_LOW_TICK_NO_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_s |=> !$rose(mod_rst_o)); // R8
endmodule

// File: tb/sclk_hold_sync_tb_top.sv
module sclk_hold_sync_tb_top;
  localparam int D = 24;

  logic clk = 1'b0, rst_ni = 1'b0, sclk = 1'b0, tick = 1'b0;
  logic mod_rst, ovr_en, ovr_val, restart;

  sclk_hold_sync #(.SYNC_STAGES(2), .HOLD_TICKS(4), .RESTART_DLY(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .rdy_tick_i(tick),
    .mod_rst_o(mod_rst), .pin_ovr_en_o(ovr_en), .pin_ovr_val_o(ovr_val),
    .restart_o(restart)
  );

  always #10 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit done = 0;
  int unsigned q_cyc[$];
  logic [3:0]  q_exp[$];
  string       q_tag[$];

  function automatic logic [3:0] obs();
    return {mod_rst, ovr_en, ovr_val, restart};
  endfunction

  task automatic expect_at(int unsigned c, logic [3:0] v, string tag);
    q_cyc.push_back(c); q_exp.push_back(v); q_tag.push_back(tag);
  endtask

  task automatic check_now(logic [3:0] v, string tag);
    checks++;
    if (obs() !== v) begin
      failures++;
      $display("FAIL %s cyc=%0d got=%b exp=%b", tag, cyc, obs(), v);
    end
  endtask

  // monitor: compare scoreboard items when their cycle comes up
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      if (q_cyc[0] == cyc) check_now(q_exp[0], q_tag[0]);
      else begin
        checks++; failures++;
        $display("FAIL %s missed cyc=%0d got=- exp=%b", q_tag[0], q_cyc[0], q_exp[0]);
      end
      void'(q_cyc.pop_front()); void'(q_exp.pop_front()); void'(q_tag.pop_front());
    end
  end

  task automatic set_sclk(logic v);
    sclk = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic tick_once(logic [3:0] v, string tag);
    tick = 1'b1;
    expect_at(cyc + 1, v, tag);
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic tick_enter();
    tick = 1'b1;
    expect_at(cyc + 1, 4'b1100, "R2");
    expect_at(cyc + 2, 4'b1110, "R4");
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_full();
    int unsigned n;
    n = cyc;
    sclk = 1'b0;
    expect_at(n + 2, 4'b1110, "R6");
    expect_at(n + 3, 4'b0110, "R6");
    expect_at(n + D + 1, 4'b0110, "R7");
    expect_at(n + D + 2, 4'b0111, "R7");
    expect_at(n + D + 3, 4'b0000, "R7");
    repeat (D + 5) @(negedge clk);
  endtask

  initial begin
    int unsigned n;
    repeat (3) @(negedge clk);
    check_now(4'b0000, "R1");
    rst_ni = 1'b1;
    @(negedge clk);
    check_now(4'b0000, "R1");

    // R8: ticks with the clock low
    for (int i = 0; i < 6; i++) tick_once(4'b0000, "R8");

    // R3: partial count interrupted by a low period
    set_sclk(1'b1);
    for (int i = 0; i < 3; i++) tick_once(4'b0000, "R2");
    set_sclk(1'b0);
    set_sclk(1'b1);
    for (int i = 0; i < 3; i++) tick_once(4'b0000, "R3");
    tick_enter();

    // R5: further ticks keep reset
    for (int i = 0; i < 5; i++) tick_once(4'b1110, "R5");
    release_full();

    // R9: clock high again inside the restart window
    set_sclk(1'b1);
    for (int i = 0; i < 3; i++) tick_once(4'b0000, "R2");
    tick_enter();
    n = cyc;
    sclk = 1'b0;
    expect_at(n + 2, 4'b1110, "R6");
    expect_at(n + 3, 4'b0110, "R6");
    repeat (5) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) tick_once(4'b0110, "R9");
    expect_at(n + D + 2, 4'b0111, "R7");
    expect_at(n + D + 3, 4'b0000, "R7");
    while (cyc < n + D + 5) @(negedge clk);
    for (int i = 0; i < 3; i++) tick_once(4'b0000, "R9");
    tick_enter();
    release_full();

    while (q_cyc.size() > 0) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog cyc=%0d got=hung exp=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule